// File: doc/BRIEF.md
# Chained Double-Buffered DMA Channel

This block is one DMA channel that moves 32-bit words between a device-side stream and a simple memory port, one address segment at a time. The channel keeps an active segment (a running address and an end address) and a queued segment (a start and a stop address). When the active segment finishes and the queue is armed, the channel loads the queued segment into the active registers without stopping. Transfers therefore run back to back with no software action between them.

Software drives the channel through a small register file. It resets the channel and picks a direction. It loads the active and queued addresses, then enables the channel, arming the queue only if a queued segment exists. At each segment end the channel sets a completion flag, which is also the interrupt line. It records the address at which the segment stopped. Software then clears the flag and may arm a new queued segment. A segment end with nothing armed, or an error response from memory, shuts the channel down.

Top module: `dma_chain_chan`

## Requirements
- R1: After rst_n is released, reading the control/status word (index 0) returns 0, the eight address registers read 0, irq is low and mem_req is low.
- R2: The eight address registers at indices 1 to 8 read back exactly what was last written, including bit 31. The indices are 1 running address, 2 end address, 3 queued start, 4 queued stop, 5 to 8 their saved copies in the same order.
- R3: A write to index 0 is a set of one-shot commands, and any combination may appear in one write. The command bits are: bit0 reset, bit1 clear-done, bit2 set-enable, bit3 arm-queue, bit4 direction memory-to-device, bit5 direction device-to-memory, bit6 flush-buffer. Reset clears all status first, and the other bits of the same write then take effect. If both direction bits are set, memory-to-device wins. Status reads as bit0 enable, bit1 armed, bit2 done, bit3 bus-error, bit4 memory-to-device.
- R4: When the running address equals the end address and the queue is armed, the channel copies the queued start and stop into the running and end registers. Enable stays set, armed clears, and done sets.
- R5: When the running address equals the end address and the queue is not armed, enable clears and done sets. This includes a segment of zero length, which ends with no memory access.
- R6: Bit 31 of any address register is a flag. It is ignored in the end comparison and is never driven on mem_addr, and it is never stored into the saved end address by hardware.
- R7: At every segment end, the saved end address (index 6) takes the address at which the segment stopped, with bit 31 cleared. After a full segment this equals the end address.
- R8: In device-to-memory mode, each accepted device word is written to memory at the running address, and the running address then advances by 4.
- R9: In memory-to-device mode, each word read from memory appears on dev_out_data with dev_out_valid high for one cycle, in address order.
- R10: While mem_req is high and neither mem_ack nor mem_err has come, mem_req stays high and mem_addr stays stable.
- R11: An error response on the memory port sets bus-error and done, and clears enable and armed. The failing address is left in the running address and copied into the saved end address.
- R12: irq follows the done flag. Clear-done drops irq, and clear-done together with reset returns the status word to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| irq | output | 1 | Completion interrupt, high while done is set |
| mem_req | output | 1 | Memory request, held until ack or error |
| mem_we | output | 1 | 1 for a memory write, 0 for a read |
| mem_addr | output | 32 | Word address, bit 31 always 0 |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Request completed |
| mem_err | input | 1 | Request failed |
| dev_in_valid | input | 1 | Device word available (device-to-memory) |
| dev_in_ready | output | 1 | Channel accepts a device word this cycle |
| dev_in_data | input | 32 | Device word |
| dev_out_valid | output | 1 | Word delivered to the device this cycle |
| dev_out_data | output | 32 | Word delivered to the device |

## Verification
The assertions assume that the memory side answers a request with at most one of mem_ack or mem_err, and only while mem_req is high. They also assume that software moves no address register while a request is pending, and that address registers hold word-aligned values. The bench's memory model responds only to a live request, after a fixed wait, and raises an error only at one chosen address. All register writes that change addresses happen while the channel is stopped or has just been reset. The only write made while the channel is running is the clear-done rearm, which touches no address.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;

    // command bit positions in a write to the control word
    localparam int CMD_RESET     = 0;
    localparam int CMD_CLR_DONE  = 1;
    localparam int CMD_SET_EN    = 2;
    localparam int CMD_ARM       = 3;
    localparam int CMD_TO_DEV    = 4;
    localparam int CMD_TO_MEM    = 5;
    localparam int CMD_FLUSH     = 6;

    localparam int STATUS_W      = 5;

    typedef enum logic [3:0] {
        RA_CTRL   = 4'd0,
        RA_NEXT   = 4'd1,
        RA_LIMIT  = 4'd2,
        RA_START  = 4'd3,
        RA_STOP   = 4'd4,
        RA_SNEXT  = 4'd5,
        RA_SLIMIT = 4'd6,
        RA_SSTART = 4'd7,
        RA_SSTOP  = 4'd8
    } reg_idx_e;

    // packed MSB first: en lands in bit 0 of the status word
    typedef struct packed {
        logic to_dev;
        logic berr;
        logic done;
        logic armed;
        logic en;
    } chan_status_t;

    typedef enum logic [0:0] {
        ENG_IDLE = 1'b0,
        ENG_BUSY = 1'b1
    } eng_state_e;

endpackage

// File: rtl/dma_seg_cmp.sv
module dma_seg_cmp #(
    parameter int AW = 32
) (
    input  logic [AW-2:0] nxt_low,
    input  logic [AW-2:0] lim_low,
    output logic          at_end,
    output logic [AW-1:0] bus_addr
);

    // the top address bit is a flag and takes no part in comparison or bus drive
    always_comb begin
        at_end   = (nxt_low == lim_low);
        bus_addr = {1'b0, nxt_low};
    end

endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
    import dma_chain_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic          to_dev,
    input  logic          flush,
    input  logic [AW-1:0] addr,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ack,
    input  logic          mem_err,
    input  logic          dev_in_valid,
    output logic          dev_in_ready,
    input  logic [DW-1:0] dev_in_data,
    output logic          dev_out_valid,
    output logic [DW-1:0] dev_out_data,
    output logic          step,
    output logic          fault,
    output logic          busy
);

    typedef struct packed {
        eng_state_e    st;
        logic          we;
        logic [DW-1:0] hold;
        logic          ov;
        logic [DW-1:0] od;
    } eng_t;

    eng_t q, d;

    always_comb begin
        d            = q;
        d.ov         = 1'b0;
        step         = 1'b0;
        fault        = 1'b0;
        dev_in_ready = 1'b0;
        if (flush) begin
            d.st   = ENG_IDLE;
            d.hold = '0;
        end else begin
            case (q.st)
                ENG_IDLE: begin
                    if (go) begin
                        if (to_dev) begin
                            d.st = ENG_BUSY;
                            d.we = 1'b0;
                        end else begin
                            dev_in_ready = 1'b1;
                            if (dev_in_valid) begin
                                d.hold = dev_in_data;
                                d.we   = 1'b1;
                                d.st   = ENG_BUSY;
                            end
                        end
                    end
                end
                ENG_BUSY: begin
                    if (mem_err) begin
                        fault = 1'b1;
                        d.st  = ENG_IDLE;
                    end else if (mem_ack) begin
                        step = 1'b1;
                        d.st = ENG_IDLE;
                        if (!q.we) begin
                            d.ov = 1'b1;
                            d.od = mem_rdata;
                        end
                    end
                end
                default: d.st = ENG_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ENG_IDLE, we: 1'b0, hold: '0, ov: 1'b0, od: '0};
        end else begin
            q <= d;
        end
    end

    assign busy          = (q.st == ENG_BUSY);
    assign mem_req       = busy;
    assign mem_we        = q.we;
    assign mem_addr      = addr;
    assign mem_wdata     = q.hold;
    assign dev_out_valid = q.ov;
    assign dev_out_data  = q.od;

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_chain_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [3:0]    reg_addr,
    input  logic [AW-1:0] reg_wdata,
    output logic [AW-1:0] reg_rdata,
    input  logic          step,
    input  logic          fault,
    input  logic          busy,
    input  logic          at_end,
    output chan_status_t  sts,
    output logic [AW-2:0] nxt_low,
    output logic [AW-2:0] lim_low,
    output logic          flush,
    output logic          irq
);

    localparam int         STEP_BYTES = DW / 8;
    localparam logic [AW-2:0] STEP_INC = (AW-1)'(STEP_BYTES);

    typedef struct packed {
        chan_status_t  st;
        logic [AW-1:0] nxt;
        logic [AW-1:0] lim;
        logic [AW-1:0] sta;
        logic [AW-1:0] sto;
        logic [AW-1:0] s_nxt;
        logic [AW-1:0] s_lim;
        logic [AW-1:0] s_sta;
        logic [AW-1:0] s_sto;
    } regs_t;

    regs_t q, d;
    logic  end_evt;
    logic [AW-1:0] stop_addr;

    always_comb begin
        d         = q;
        flush     = 1'b0;
        end_evt   = q.st.en && at_end && !busy;
        stop_addr = {1'b0, q.nxt[AW-2:0]};

        // hardware events first
        if (fault) begin
            d.st.berr  = 1'b1;
            d.st.done  = 1'b1;
            d.st.en    = 1'b0;
            d.st.armed = 1'b0;
            d.s_lim    = stop_addr;
        end else if (step) begin
            d.nxt = {q.nxt[AW-1], q.nxt[AW-2:0] + STEP_INC};
        end else if (end_evt) begin
            d.st.done = 1'b1;
            d.s_lim   = stop_addr;
            if (q.st.armed) begin
                d.nxt      = q.sta;
                d.lim      = q.sto;
                d.s_nxt    = q.sta;
                d.st.armed = 1'b0;
            end else begin
                d.st.en = 1'b0;
            end
        end

        // software writes take precedence
        if (reg_we) begin
            case (reg_idx_e'(reg_addr))
                RA_CTRL: begin
                    if (reg_wdata[CMD_RESET]) begin
                        d.st  = '0;
                        flush = 1'b1;
                    end
                    if (reg_wdata[CMD_FLUSH])    flush      = 1'b1;
                    if (reg_wdata[CMD_CLR_DONE]) d.st.done  = 1'b0;
                    if (reg_wdata[CMD_TO_MEM])   d.st.to_dev = 1'b0;
                    if (reg_wdata[CMD_TO_DEV])   d.st.to_dev = 1'b1;
                    if (reg_wdata[CMD_SET_EN])   d.st.en    = 1'b1;
                    if (reg_wdata[CMD_ARM])      d.st.armed = 1'b1;
                end
                RA_NEXT:   d.nxt   = reg_wdata;
                RA_LIMIT:  d.lim   = reg_wdata;
                RA_START:  d.sta   = reg_wdata;
                RA_STOP:   d.sto   = reg_wdata;
                RA_SNEXT:  d.s_nxt = reg_wdata;
                RA_SLIMIT: d.s_lim = reg_wdata;
                RA_SSTART: d.s_sta = reg_wdata;
                RA_SSTOP:  d.s_sto = reg_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        case (reg_idx_e'(reg_addr))
            RA_CTRL:   reg_rdata = {{(AW-STATUS_W){1'b0}}, q.st};
            RA_NEXT:   reg_rdata = q.nxt;
            RA_LIMIT:  reg_rdata = q.lim;
            RA_START:  reg_rdata = q.sta;
            RA_STOP:   reg_rdata = q.sto;
            RA_SNEXT:  reg_rdata = q.s_nxt;
            RA_SLIMIT: reg_rdata = q.s_lim;
            RA_SSTART: reg_rdata = q.s_sta;
            RA_SSTOP:  reg_rdata = q.s_sto;
            default:   reg_rdata = '0;
        endcase
    end

    assign sts     = q.st;
    assign nxt_low = q.nxt[AW-2:0];
    assign lim_low = q.lim[AW-2:0];
    assign irq     = q.st.done;

endmodule

// File: rtl/dma_chain_chan.sv
module dma_chain_chan
    import dma_chain_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [3:0]    reg_addr,
    input  logic [AW-1:0] reg_wdata,
    output logic [AW-1:0] reg_rdata,
    output logic          irq,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ack,
    input  logic          mem_err,
    input  logic          dev_in_valid,
    output logic          dev_in_ready,
    input  logic [DW-1:0] dev_in_data,
    output logic          dev_out_valid,
    output logic [DW-1:0] dev_out_data
);

    chan_status_t  sts;
    logic [AW-2:0] nxt_low;
    logic [AW-2:0] lim_low;
    logic [AW-1:0] bus_addr;
    logic          at_end;
    logic          flush;
    logic          eng_step;
    logic          eng_fault;
    logic          eng_busy;
    logic          eng_go;

    assign eng_go = sts.en && !at_end;

    dma_chan_regs #(.AW(AW), .DW(DW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .step      (eng_step),
        .fault     (eng_fault),
        .busy      (eng_busy),
        .at_end    (at_end),
        .sts       (sts),
        .nxt_low   (nxt_low),
        .lim_low   (lim_low),
        .flush     (flush),
        .irq       (irq)
    );

    dma_seg_cmp #(.AW(AW)) u_cmp (
        .nxt_low  (nxt_low),
        .lim_low  (lim_low),
        .at_end   (at_end),
        .bus_addr (bus_addr)
    );

    dma_xfer_engine #(.AW(AW), .DW(DW)) u_eng (
        .clk           (clk),
        .rst_n         (rst_n),
        .go            (eng_go),
        .to_dev        (sts.to_dev),
        .flush         (flush),
        .addr          (bus_addr),
        .mem_req       (mem_req),
        .mem_we        (mem_we),
        .mem_addr      (mem_addr),
        .mem_wdata     (mem_wdata),
        .mem_rdata     (mem_rdata),
        .mem_ack       (mem_ack),
        .mem_err       (mem_err),
        .dev_in_valid  (dev_in_valid),
        .dev_in_ready  (dev_in_ready),
        .dev_in_data   (dev_in_data),
        .dev_out_valid (dev_out_valid),
        .dev_out_data  (dev_out_data),
        .step          (eng_step),
        .fault         (eng_fault),
        .busy          (eng_busy)
    );

endmodule

// File: rtl/dma_chain_chk.sv
module dma_chain_chk
    import dma_chain_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_we,
    input logic          mem_req,
    input logic          mem_ack,
    input logic          mem_err,
    input logic [AW-1:0] mem_addr,
    input logic          irq,
    input chan_status_t  sts,
    input logic          step,
    input logic [AW-2:0] nxt_low
);

    localparam logic [AW-2:0] STEP_INC = (AW-1)'(DW / 8);

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack && !mem_err && !reg_we |=> mem_req && $stable(mem_addr)); // R10

    AST_FLAG_NOT_ON_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !mem_addr[AW-1]); // R6

    AST_ERR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_err && !reg_we |=> irq && !sts.en && sts.berr); // R11

    AST_HANDOFF_KEEPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sts.armed) && !$past(reg_we) && !$past(mem_err) |-> sts.en && sts.done); // R4

    AST_SHUTDOWN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sts.en) && !$past(reg_we) |-> sts.done); // R5

    AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        step && !reg_we |=> nxt_low == $past(nxt_low) + STEP_INC); // R8

endmodule

bind dma_chain_chan dma_chain_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_we   (reg_we),
    .mem_req  (mem_req),
    .mem_ack  (mem_ack),
    .mem_err  (mem_err),
    .mem_addr (mem_addr),
    .irq      (irq),
    .sts      (sts),
    .step     (eng_step),
    .nxt_low  (nxt_low)
);

// File: tb/tb_dma_chain_chan.sv
module tb_dma_chain_chan;
    localparam int AW  = 32;
    localparam int DW  = 32;
    localparam int LAT = 1;

    localparam logic [31:0] C_RST = 32'h01, C_CLR = 32'h02, C_EN = 32'h04, C_ARM = 32'h08;
    localparam logic [31:0] C_TODEV = 32'h10, C_TOMEM = 32'h20, C_FLUSH = 32'h40;
    localparam logic [31:0] S_EN = 32'h01, S_ARM = 32'h02, S_DONE = 32'h04, S_BERR = 32'h08, S_TODEV = 32'h10;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [3:0]    reg_addr = '0;
    logic [AW-1:0] reg_wdata = '0;
    logic [AW-1:0] reg_rdata;
    logic          irq;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic          mem_ack = 1'b0, mem_err = 1'b0;
    logic          dev_in_valid = 1'b0;
    logic          dev_in_ready;
    logic [DW-1:0] dev_in_data = '0;
    logic          dev_out_valid;
    logic [DW-1:0] dev_out_data;

    dma_chain_chan #(.AW(AW), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .mem_err(mem_err), .dev_in_valid(dev_in_valid), .dev_in_ready(dev_in_ready),
        .dev_in_data(dev_in_data), .dev_out_valid(dev_out_valid), .dev_out_data(dev_out_data)
    );

    int n_checks = 0;
    int n_err    = 0;
    bit done_run = 1'b0;

    logic [DW-1:0] mem [0:255];
    logic [AW-1:0] exp_wa [$];
    logic [DW-1:0] exp_wd [$];
    logic [DW-1:0] exp_out [$];
    logic [DW-1:0] src [$];
    int            src_idx = 0;
    bit            src_taken = 1'b0;
    logic [AW-1:0] err_addr = 32'h7FFF_FFF0;
    int            lat_cnt = 0;
    logic [AW-1:0] hold_addr = '0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // memory model, device source and device sink: the scoreboard monitor
    always @(negedge clk) begin
        mem_ack = 1'b0;
        mem_err = 1'b0;
        if (mem_req) begin
            if (lat_cnt == 0) hold_addr = mem_addr;
            else chk(mem_addr === hold_addr, "R10 address held", mem_addr, hold_addr);
            if (lat_cnt == LAT) begin
                lat_cnt = 0;
                if (mem_addr == err_addr) begin
                    mem_err = 1'b1;
                end else begin
                    mem_ack = 1'b1;
                    if (mem_we) begin
                        if (exp_wa.size() == 0) begin
                            chk(1'b0, "R8 unexpected write", mem_addr, 32'h0);
                        end else begin
                            logic [AW-1:0] ea;
                            logic [DW-1:0] ed;
                            ea = exp_wa.pop_front();
                            ed = exp_wd.pop_front();
                            chk(mem_addr == ea, "R8 write address", mem_addr, ea);
                            chk(mem_wdata == ed, "R8 write data", mem_wdata, ed);
                        end
                        mem[mem_addr[9:2]] = mem_wdata;
                    end else begin
                        mem_rdata = mem[mem_addr[9:2]];
                    end
                end
            end else begin
                lat_cnt++;
            end
        end else begin
            lat_cnt = 0;
        end

        if (dev_out_valid) begin
            if (exp_out.size() == 0) chk(1'b0, "R9 unexpected device word", dev_out_data, 32'h0);
            else begin
                logic [DW-1:0] eo;
                eo = exp_out.pop_front();
                chk(dev_out_data == eo, "R9 device word", dev_out_data, eo);
            end
        end

        if (src_taken) src_idx++;
        src_taken    = 1'b0;
        dev_in_valid = (src_idx < src.size());
        dev_in_data  = dev_in_valid ? src[src_idx] : '0;
        if (dev_in_valid && dev_in_ready) src_taken = 1'b1;
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string tag);
        logic [31:0] v;
        rd(a, v);
        chk(v == exp, tag, v, exp);
    endtask

    task automatic wait_irq(input string tag);
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            #1;
            if (irq) break;
        end
        chk(irq === 1'b1, tag, {31'b0, irq}, 32'h1);
    endtask

    task automatic finish_run();
        if (!done_run) begin
            done_run = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(negedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finished");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd_chk(4'd0, 32'h0, "R1 status after reset");
        rd_chk(4'd1, 32'h0, "R1 running address after reset");
        rd_chk(4'd6, 32'h0, "R1 saved end after reset");
        chk(irq == 1'b0 && mem_req == 1'b0, "R1 irq and mem_req low", {30'b0, irq, mem_req}, 32'h0);

        // R2: address register readback including flag bit
        for (int i = 1; i <= 8; i++) wr(4'(i), 32'h8000_0000 | (i << 12) | 32'h0000_0A5C);
        for (int i = 1; i <= 8; i++) rd_chk(4'(i), 32'h8000_0000 | (i << 12) | 32'h0000_0A5C, "R2 readback");

        // R3: combined commands, reset first then the rest
        wr(4'd0, C_RST | C_TODEV | C_ARM);
        rd_chk(4'd0, S_TODEV | S_ARM, "R3 reset with direction and arm");
        wr(4'd0, C_TOMEM | C_TODEV);
        rd_chk(4'd0, S_TODEV | S_ARM, "R3 both direction bits");
        wr(4'd0, C_RST);
        rd_chk(4'd0, 32'h0, "R3 reset clears status");

        // R8 R4 R6 R7: device-to-memory, chained into a second segment with flag bit
        wr(4'd0, C_RST | C_FLUSH | C_TOMEM);
        wr(4'd1, 32'h0000_0100);
        wr(4'd2, 32'h0000_0110);
        wr(4'd3, 32'h0000_0200);
        wr(4'd4, 32'h8000_0210);
        for (int i = 0; i < 4; i++) begin
            exp_wa.push_back(32'h100 + 4 * i); exp_wd.push_back(32'hA000_0000 + i);
            src.push_back(32'hA000_0000 + i);
        end
        for (int i = 0; i < 4; i++) begin
            exp_wa.push_back(32'h200 + 4 * i); exp_wd.push_back(32'hB000_0000 + i);
            src.push_back(32'hB000_0000 + i);
        end
        wr(4'd0, C_EN | C_ARM);
        wait_irq("R4 first segment interrupt");
        rd_chk(4'd0, S_EN | S_DONE, "R4 handoff keeps enable, consumes arm");
        rd_chk(4'd6, 32'h0000_0110, "R7 saved end after full segment");
        rd_chk(4'd2, 32'h8000_0210, "R4 stop copied into end register");
        wr(4'd0, C_CLR | C_TOMEM);
        #1 chk(irq == 1'b0, "R12 clear-done drops irq", {31'b0, irq}, 32'h0);
        wait_irq("R5 second segment interrupt");
        rd_chk(4'd0, S_DONE, "R5 unarmed end shuts down");
        rd_chk(4'd6, 32'h0000_0210, "R6 saved end without flag bit");
        chk(exp_wa.size() == 0, "R8 all words written", exp_wa.size(), 32'h0);
        chk(mem[8'h83] == 32'hB000_0003, "R8 last word in memory", mem[8'h83], 32'hB000_0003);

        // R9: memory-to-device, single unarmed segment
        wr(4'd0, C_CLR | C_RST | C_FLUSH | C_TODEV);
        wr(4'd1, 32'h0000_0100);
        wr(4'd2, 32'h0000_010C);
        for (int i = 0; i < 3; i++) exp_out.push_back(32'hA000_0000 + i);
        wr(4'd0, C_EN);
        wait_irq("R9 read segment interrupt");
        repeat (2) @(negedge clk);
        rd_chk(4'd0, S_DONE | S_TODEV, "R9 status after read segment");
        rd_chk(4'd6, 32'h0000_010C, "R7 saved end after read segment");
        chk(exp_out.size() == 0, "R9 all words delivered", exp_out.size(), 32'h0);

        // R11: bus error in the middle of an armed segment
        mem[8'hC0] = 32'hC0DE_0000;
        mem[8'hC1] = 32'hC0DE_0001;
        wr(4'd0, C_CLR | C_RST | C_TODEV);
        wr(4'd1, 32'h0000_0300);
        wr(4'd2, 32'h0000_0320);
        wr(4'd3, 32'h0000_0400);
        wr(4'd4, 32'h0000_0410);
        err_addr = 32'h0000_0308;
        exp_out.push_back(32'hC0DE_0000);
        exp_out.push_back(32'hC0DE_0001);
        wr(4'd0, C_EN | C_ARM);
        wait_irq("R11 error interrupt");
        repeat (2) @(negedge clk);
        rd_chk(4'd0, S_DONE | S_BERR | S_TODEV, "R11 status after bus error");
        rd_chk(4'd6, 32'h0000_0308, "R11 saved end is failing address");
        rd_chk(4'd1, 32'h0000_0308, "R11 running address at failure");
        chk(exp_out.size() == 0, "R11 words before failure delivered", exp_out.size(), 32'h0);
        chk(mem_req == 1'b0, "R11 no request after error", {31'b0, mem_req}, 32'h0);
        err_addr = 32'h7FFF_FFF0;

        // R5: zero-length segment ends at once with no access
        wr(4'd0, C_CLR | C_RST | C_TOMEM);
        wr(4'd1, 32'h0000_0500);
        wr(4'd2, 32'h8000_0500);
        wr(4'd0, C_EN);
        wait_irq("R5 zero-length interrupt");
        rd_chk(4'd0, S_DONE, "R5 zero-length shutdown");
        rd_chk(4'd6, 32'h0000_0500, "R7 saved end of empty segment");

        // R12: clear-done with reset stops everything
        wr(4'd0, C_CLR | C_RST);
        rd_chk(4'd0, 32'h0, "R12 stop command clears status");
        chk(irq == 1'b0, "R12 irq low after stop", {31'b0, irq}, 32'h0);

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule